// File: doc/BRIEF.md
# Watermarked UART Transmitter

This block is the transmit half of a UART. A write port pushes bytes into a small FIFO. A shift register sends each byte on a serial line as an 8N1 frame, using a 16x oversampling tick that arrives as an input. A status flag, `tx_empty_o`, tells software when the FIFO has drained to a programmable watermark. Software can write whenever the flag is high or the FIFO still has room.

The FIFO hands its next word to the shifter at a fixed point inside the stop bit of the frame on the line, 9/16 of a bit after the stop bit begins. The flag is evaluated at that same moment, so frames follow each other with no gap. With the watermark at 0, a rising flag means the last written byte has left the FIFO.

A low-to-high change on the enable input queues one preamble. A preamble is a full idle character of ones. It goes out after the frame in progress and ahead of any queued data, so software can mark a message boundary with the shortest possible idle time.

Top module: `uart_tx_wm`

## Requirements
- R1: A frame is a start bit (0), then 8 data bits sent LSB first, then a stop bit (1). Each bit lasts exactly 16 ticks, and `tx_o` changes only on a tick.
- R2: After reset, `tx_o` is 1 and `tx_empty_o` is 1. Whenever the FIFO is empty and no frame or preamble is in flight, `tx_o` stays 1.
- R3: While a frame is on the line and another word is queued, the FIFO pops on the 9th tick of the stop bit (tick 153 counted from the start-bit edge). The next start bit begins 160 ticks after the previous one.
- R4: At every load into the shifter, `tx_empty_o` is set if the FIFO count after the pop is at or below `watermark_i`, and cleared otherwise. An accepted write that raises the count above the watermark clears it. Nothing else changes the flag.
- R5: With a watermark of 0, the flag rises exactly when the last queued word moves into the shifter. From idle, that is the tick of its start bit.
- R6: Each 0-to-1 change of `tx_en_i` queues one preamble of 160 ticks of ones. It follows the frame in progress, or starts on the next tick if the line is idle, and queued data begins right after it. Enabling from idle with data waiting therefore puts the first start bit 161 ticks after the enabling tick.
- R7: While `tx_en_i` is 0, no new frame or preamble begins. The line returns to 1 once any frame in flight completes, and writes still fill the FIFO.
- R8: The FIFO holds DEPTH (default 8) words and sends them in write order. A write while it is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| tx_en_i | input | 1 | Transmit enable; a rising edge queues a preamble |
| wr_en_i | input | 1 | Push `wr_data_i` into the FIFO |
| wr_data_i | input | DW | Byte to transmit |
| watermark_i | input | CW | Flag threshold on the FIFO count |
| tx_o | output | 1 | Serial output, idle high |
| tx_empty_o | output | 1 | Transmit-empty flag tied to the watermark |

## Verification
The bench decodes the serial line at mid-bit and records the tick of every start bit and every rising edge of the flag.

- **Load point and spacing:** it measures back-to-back spacing and the exact tick of the watermark-driven flag rise. A design that loads at the end of the stop bit, or sets the flag on a write or on the wrong count, shows up as a frame gap or a flag edge a few ticks off.
- **Preamble:** it toggles enable in the middle of a frame and also enables from idle with a full FIFO, then checks the 320-tick and 161-tick offsets. A preamble that is missing, cuts into the current frame, or is one bit short moves those offsets.
- **Full FIFO:** it writes a ninth byte into a full FIFO. An overwrite, or a ninth frame, would reveal a design that accepted it.

// File: rtl/uart_tx_wm_pkg.sv
package uart_tx_wm_pkg;
  localparam int unsigned OSR      = 16;
  localparam int unsigned SUB_W    = $clog2(OSR);
  localparam int unsigned LOAD_SUB = (OSR * 9) / 16 - 1;
  localparam int unsigned PRE_BITS = 10;
  localparam int unsigned BIT_W    = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_PRE
  } tx_state_e;
endpackage

// File: rtl/uart_tx_wm_fifo.sv
module uart_tx_wm_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 8,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] dout_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem_q[rd_q];
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
      if (do_pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/uart_tx_wm_shifter.sv
module uart_tx_wm_shifter
  import uart_tx_wm_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             pre_pend_i,
  input  logic             fifo_empty_i,
  input  logic [DW-1:0]    fifo_data_i,
  output logic             pop_o,
  output logic             pre_ack_o,
  output logic             tx_o,
  output tx_state_e        state_o,
  output logic [SUB_W-1:0] sub_o
);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);
  localparam logic [SUB_W-1:0] SUB_LOAD = SUB_W'(LOAD_SUB);

  tx_state_e        state_q, state_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [DW-1:0]    sh_q, sh_d;
  logic             ld_q, ld_d;

  always_comb begin
    state_d   = state_q;
    sub_d     = sub_q;
    bit_d     = bit_q;
    sh_d      = sh_q;
    ld_d      = ld_q;
    pop_o     = 1'b0;
    pre_ack_o = 1'b0;
    if (tick_i) begin
      sub_d = sub_q + SUB_W'(1);
      unique case (state_q)
        ST_IDLE: begin
          sub_d = '0;
          bit_d = '0;
          if (en_i && pre_pend_i) begin
            state_d   = ST_PRE;
            pre_ack_o = 1'b1;
          end else if (en_i && !fifo_empty_i) begin
            state_d = ST_START;
            sh_d    = fifo_data_i;
            pop_o   = 1'b1;
          end
        end
        ST_START: begin
          if (sub_q == SUB_LAST) begin
            state_d = ST_DATA;
            bit_d   = '0;
          end
        end
        ST_DATA: begin
          if (sub_q == SUB_LAST) begin
            sh_d  = sh_q >> 1;
            bit_d = bit_q + BIT_W'(1);
            if (bit_q == BIT_W'(DW - 1)) state_d = ST_STOP;
          end
        end
        ST_STOP: begin
          // hand-off point inside the stop bit
          if (sub_q == SUB_LOAD && en_i && !pre_pend_i && !fifo_empty_i) begin
            sh_d  = fifo_data_i;
            pop_o = 1'b1;
            ld_d  = 1'b1;
          end
          if (sub_q == SUB_LAST) begin
            ld_d  = 1'b0;
            bit_d = '0;
            if (ld_q) begin
              state_d = ST_START;
            end else if (en_i && pre_pend_i) begin
              state_d   = ST_PRE;
              pre_ack_o = 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_PRE: begin
          if (sub_q == SUB_LAST) begin
            bit_d = bit_q + BIT_W'(1);
            if (bit_q == BIT_W'(PRE_BITS - 1)) begin
              bit_d = '0;
              if (en_i && !fifo_empty_i) begin
                state_d = ST_START;
                sh_d    = fifo_data_i;
                pop_o   = 1'b1;
              end else begin
                state_d = ST_IDLE;
              end
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sub_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      ld_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      sub_q   <= sub_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      ld_q    <= ld_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: tx_o = 1'b0;
      ST_DATA:  tx_o = sh_q[0];
      default:  tx_o = 1'b1;
    endcase
  end

  assign state_o = state_q;
  assign sub_o   = sub_q;
endmodule

// File: rtl/uart_tx_wm.sv
module uart_tx_wm
  import uart_tx_wm_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 8,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          tx_en_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [CW-1:0] watermark_i,
  output logic          tx_o,
  output logic          tx_empty_o
);
  logic             pop, pre_ack, fifo_full, fifo_empty, push;
  logic [DW-1:0]    fifo_dout;
  logic [CW-1:0]    fifo_cnt;
  logic [CW:0]      cnt_nx;
  tx_state_e        sh_state;
  logic [SUB_W-1:0] sh_sub;
  logic             en_q, pend_q, flag_q;

  assign push = wr_en_i && !fifo_full;

  uart_tx_wm_fifo #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (wr_en_i),
    .din_i   (wr_data_i),
    .pop_i   (pop),
    .dout_o  (fifo_dout),
    .cnt_o   (fifo_cnt),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  uart_tx_wm_shifter #(.DW(DW)) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .en_i         (tx_en_i),
    .pre_pend_i   (pend_q),
    .fifo_empty_i (fifo_empty),
    .fifo_data_i  (fifo_dout),
    .pop_o        (pop),
    .pre_ack_o    (pre_ack),
    .tx_o         (tx_o),
    .state_o      (sh_state),
    .sub_o        (sh_sub)
  );

  assign cnt_nx = (CW+1)'(fifo_cnt) + (CW+1)'(push) - (CW+1)'(pop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      flag_q <= 1'b1;
    end else begin
      en_q   <= tx_en_i;
      // enable rising edge queues one preamble
      pend_q <= (pend_q && !pre_ack) || (tx_en_i && !en_q);
      if (pop)                                            flag_q <= (cnt_nx <= (CW+1)'(watermark_i));
      else if (push && (cnt_nx > (CW+1)'(watermark_i)))  flag_q <= 1'b0;
    end
  end

  assign tx_empty_o = flag_q;
endmodule

// File: rtl/uart_tx_wm_chk.sv
module uart_tx_wm_chk
  import uart_tx_wm_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             tx_en_i,
  input logic             wr_en_i,
  input logic             tx_o,
  input logic             tx_empty_o,
  input logic             pop,
  input logic [CW-1:0]    cnt,
  input tx_state_e        state,
  input logic [SUB_W-1:0] sub
);
  // R1
  line_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tx_o) |-> $past(tick_i));

  // R2
  idle_line_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE && cnt == '0 && !tick_i) |=> tx_o);

  // R3
  stop_load_point_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_STOP && pop) |-> (tick_i && sub == SUB_W'(LOAD_SUB)));

  // R4
  flag_rise_on_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_empty_o) |-> $past(pop));

  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE && !tx_en_i) |=> (state == ST_IDLE));

  // R8
  full_write_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == CW'(DEPTH) && wr_en_i && !pop) |=> (cnt == CW'(DEPTH)));
endmodule

bind uart_tx_wm uart_tx_wm_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .tx_en_i    (tx_en_i),
  .wr_en_i    (wr_en_i),
  .tx_o       (tx_o),
  .tx_empty_o (tx_empty_o),
  .pop        (pop),
  .cnt        (fifo_cnt),
  .state      (sh_state),
  .sub        (sh_sub)
);

// File: tb/test_uart_tx_wm.sv
module test_uart_tx_wm;
  localparam int DEPTH = 8;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int NV    = 6;
  // {stimulus byte, expected decoded byte}
  localparam logic [15:0] VEC [NV] = '{16'hA5A5, 16'h0101, 16'h8080,
                                       16'hFFFF, 16'h0000, 16'h3C3C};

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          tick_i = 1'b0;
  logic          tx_en_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [7:0]    wr_data_i = '0;
  logic [CW-1:0] watermark_i = '0;
  logic          tx_o, tx_empty_o;

  int checks = 0, errors = 0;
  int tcnt = 0;
  int div = 0;
  int nf = 0, nr = 0;
  int fr_t [64];
  logic [7:0] fr_d [64];
  int rs_t [64];
  logic fl_prev = 1'b0;

  uart_tx_wm #(.DEPTH(DEPTH)) i_uart_tx_wm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .tx_en_i     (tx_en_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .watermark_i (watermark_i),
    .tx_o        (tx_o),
    .tx_empty_o  (tx_empty_o)
  );

  always #10 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    tick_i <= (div == 7);
    div    <= (div == 7) ? 0 : div + 1;
  end

  always @(posedge clk_i) if (tick_i) tcnt <= tcnt + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // line decoder
  initial begin
    int t0;
    logic [7:0] d;
    logic stp;
    forever begin
      @(negedge clk_i);
      if (rst_ni && tx_o === 1'b0) begin
        t0 = tcnt;
        for (int k = 1; k <= 9; k++) begin
          while (tcnt != t0 + 16 * k + 8) @(negedge clk_i);
          if (k <= 8) d[k-1] = tx_o;
          else stp = tx_o;
        end
        chk(stp === 1'b1, "R1 stop bit", int'(stp), 1);
        fr_d[nf] = d;
        fr_t[nf] = t0;
        nf++;
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && tx_empty_o && !fl_prev) begin
      rs_t[nr] = tcnt;
      nr++;
    end
    fl_prev = tx_empty_o;
  end

  task automatic push(input logic [7:0] d);
    wr_en_i   = 1'b1;
    wr_data_i = d;
    @(negedge clk_i);
    wr_en_i   = 1'b0;
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) @(posedge clk_i iff tick_i);
    @(negedge clk_i);
  endtask

  task automatic sync_tick();
    @(posedge clk_i iff tick_i);
    @(negedge clk_i);
  endtask

  task automatic wait_frames(input int n);
    while (nf < n) @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int e, f0, r0;
    repeat (5) @(negedge clk_i);
    chk(tx_o === 1'b1, "R2 reset line", int'(tx_o), 1);
    chk(tx_empty_o === 1'b1, "R2 reset flag", int'(tx_empty_o), 1);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // table walk, watermark 0, enabled from idle after filling
    for (int i = 0; i < NV; i++) push(VEC[i][15:8]);
    wait_ticks(40);
    chk(nf == 0, "R7 no frame while disabled", nf, 0);
    chk(tx_o === 1'b1, "R7 line high while disabled", int'(tx_o), 1);
    chk(tx_empty_o === 1'b0, "R4 flag cleared by writes", int'(tx_empty_o), 0);
    r0 = nr;
    sync_tick();
    e = tcnt;
    tx_en_i = 1'b1;
    wait_frames(NV);
    chk(fr_t[0] == e + 161, "R6 preamble from idle", fr_t[0], e + 161);
    for (int i = 0; i < NV; i++) begin
      chk(fr_d[i] == VEC[i][7:0], "R1 data order", int'(fr_d[i]), int'(VEC[i][7:0]));
      if (i > 0) chk(fr_t[i] == fr_t[i-1] + 160, "R3 back-to-back spacing", fr_t[i] - fr_t[i-1], 160);
    end
    chk(nr == r0 + 1, "R5 single flag rise", nr - r0, 1);
    chk(rs_t[r0] == fr_t[NV-2] + 153, "R5 rise at last load", rs_t[r0], fr_t[NV-2] + 153);

    // preamble between messages
    wait_ticks(20);
    f0 = nf; r0 = nr;
    push(8'h55);
    while (nr == r0) @(negedge clk_i);
    sync_tick();
    tx_en_i = 1'b0;
    @(negedge clk_i);
    tx_en_i = 1'b1;
    push(8'h81);
    push(8'h7E);
    wait_frames(f0 + 3);
    chk(fr_d[f0] == 8'h55, "R1 data 55", int'(fr_d[f0]), 'h55);
    chk(fr_d[f0+1] == 8'h81, "R1 data 81", int'(fr_d[f0+1]), 'h81);
    chk(fr_d[f0+2] == 8'h7E, "R1 data 7E", int'(fr_d[f0+2]), 'h7E);
    chk(fr_t[f0+1] == fr_t[f0] + 320, "R6 preamble after frame", fr_t[f0+1] - fr_t[f0], 320);
    chk(fr_t[f0+2] == fr_t[f0+1] + 160, "R3 spacing after preamble", fr_t[f0+2] - fr_t[f0+1], 160);
    chk(rs_t[r0] == fr_t[f0], "R5 rise at idle load", rs_t[r0], fr_t[f0]);
    chk(rs_t[r0+1] == fr_t[f0+1] + 153, "R4 rise at stop load", rs_t[r0+1], fr_t[f0+1] + 153);
    chk(nr == r0 + 2, "R4 rise count", nr - r0, 2);

    // watermark 2
    wait_ticks(20);
    watermark_i = CW'(2);
    f0 = nf; r0 = nr;
    sync_tick();
    push(8'h11); push(8'h22); push(8'h44); push(8'h88);
    wait_frames(f0 + 4);
    chk(fr_d[f0+3] == 8'h88, "R8 fifo order", int'(fr_d[f0+3]), 'h88);
    chk(nr == r0 + 1, "R4 watermark rise count", nr - r0, 1);
    chk(rs_t[r0] == fr_t[f0] + 153, "R4 rise at count two", rs_t[r0], fr_t[f0] + 153);

    // full fifo, write dropped
    wait_ticks(20);
    tx_en_i = 1'b0;
    f0 = nf;
    for (int k = 0; k < DEPTH + 1; k++) push(8'(k * 29 + 3));
    chk(tx_empty_o === 1'b0, "R4 flag low above watermark", int'(tx_empty_o), 0);
    wait_ticks(20);
    chk(nf == f0, "R7 disabled holds data", nf - f0, 0);
    sync_tick();
    e = tcnt;
    tx_en_i = 1'b1;
    wait_frames(f0 + DEPTH);
    chk(fr_t[f0] == e + 161, "R6 preamble before burst", fr_t[f0], e + 161);
    for (int k = 0; k < DEPTH; k++)
      chk(fr_d[f0+k] == 8'(k * 29 + 3), "R8 full burst order", int'(fr_d[f0+k]), int'(8'(k * 29 + 3)));
    wait_ticks(400);
    chk(nf == f0 + DEPTH, "R8 ninth write dropped", nf - f0, DEPTH);
    chk(tx_o === 1'b1, "R2 idle after drain", int'(tx_o), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule